// File: doc/BRIEF.md
# Processor Operand Address Generator

This block turns the decoded fields of one instruction into either the operand value the execution stage needs or the 16-bit memory address it should use. The caller presents a mode code and the instruction fields: the register numbers for the direct register, the index and the base register, an 8-bit displacement, a 4-bit short immediate and a 16-bit address or immediate word. It also presents the current instruction counter and pulses `start` for one cycle. The block reads general registers through two combinational register-file read ports.

Every mode except memory indirect finishes in a single cycle. The indirect mode first forms a pointer address and then reads one word from memory over a request/valid interface. That word becomes the effective address. The block reports completion with a one-cycle `done` and holds `result` until the next accepted request. A flag, `is_addr`, tells the consumer whether `result` is data or an address.

Top module: `opnd_addr_gen`

## Requirements
- R1: Mode code 0 (register): `result` is the contents of register `rb`, `is_addr` is 0, and `done` is high in the cycle after the clock edge that samples `start`.
- R2: Mode code 1 (memory direct): `result` is `aword` plus register `rx` when `rx` is nonzero, and `aword` alone when `rx` is 0. `is_addr` is 1.
- R3: Mode code 2 (memory indirect): in the cycle after `start`, `mem_req` rises and `mem_addr` holds the pointer. The pointer is `aword`, plus register `rx` when `rx` is nonzero. `mem_req` and `mem_addr` stay unchanged until `mem_rvalid`. `done` follows one cycle after `mem_rvalid`, with `result` equal to `mem_rdata` and `is_addr` equal to 1. No other mode raises `mem_req`.
- R4: Mode code 3 (long immediate) returns `aword` and ignores `rx`. Mode code 4 (indexable long immediate) returns `aword` plus register `rx` when `rx` is nonzero, and `aword` when `rx` is 0. Both modes set `is_addr` to 0.
- R5: Mode code 5 (short positive) returns `simm`+1, a value from 1 to 16. Mode code 6 (short negative) returns -(`simm`+1) as a 16-bit two's-complement value. Both modes set `is_addr` to 0.
- R6: Mode code 7 (counter relative) returns `ic` - 2 plus the sign-extended `disp`, with `is_addr` equal to 1.
- R7: Mode code 8 (base) returns register (12 + `brp`) plus the zero-extended `disp`. Mode code 9 (indexed base) returns register (12 + `brp`) plus register `rx` when `rx` is nonzero, and the base register alone when `rx` is 0. Both modes set `is_addr` to 1.
- R8: Every sum wraps modulo 2^16 and no overflow is reported.
- R9: A `start` that arrives while an indirect read is outstanding is ignored: it causes no extra `done` and does not change the pending result. A `start` in the cycle that shows `done` is accepted.
- R10: Mode codes 10 to 15 complete in one cycle with `result` equal to 0 and `is_addr` equal to 0.
- R11: After reset, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a calculation with the present fields |
| mode | input | 4 | Addressing mode code |
| rb | input | 4 | Register number for register mode |
| rx | input | 4 | Index register number, 0 means no index |
| brp | input | 2 | Base register select, the register used is 12 + brp |
| disp | input | 8 | Displacement field |
| simm | input | 4 | Short immediate field |
| aword | input | 16 | Address or immediate word |
| ic | input | 16 | Instruction counter, pointing 2 past the current instruction |
| rf_a_addr | output | 4 | Register-file read port A number |
| rf_a_data | input | 16 | Register-file read port A data, same cycle |
| rf_b_addr | output | 4 | Register-file read port B number |
| rf_b_data | input | 16 | Register-file read port B data, same cycle |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read data |
| done | output | 1 | Result available, one cycle |
| result | output | 16 | Operand value or effective address |
| is_addr | output | 1 | 1 when result is an address, 0 when it is a value |

## Verification
A direct mode's `done` and `result` are due one cycle after the edge that samples `start`. An indirect request shows `mem_req` and the pointer in that same cycle. Its `done` is due one cycle after `mem_rvalid`, which is memory latency plus one cycle after the request. The bench memory runs with a selectable latency of 1 or 3 cycles. The reference model predicts, for every falling edge after a start, whether `done` must be low or high, and checks `result`, `is_addr`, `mem_req` and `mem_addr` in exactly the cycle each becomes valid. A `start` injected while the read is outstanding is checked for having no visible effect at the ports.

// File: rtl/oag_pkg.sv
// Shared definitions for the operand address generator.
// Assumes a 4-bit mode code; codes not listed below are treated as undefined.
package oag_pkg;

    typedef enum logic [3:0] {
        M_REG   = 4'd0,
        M_MDIR  = 4'd1,
        M_MIND  = 4'd2,
        M_IMML  = 4'd3,
        M_IMMLX = 4'd4,
        M_ISP   = 4'd5,
        M_ISN   = 4'd6,
        M_ICR   = 4'd7,
        M_BASE  = 4'd8,
        M_BASEX = 4'd9
    } oag_mode_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_READ_PTR = 2'd1,
        S_DONE     = 2'd2
    } oag_state_e;

endpackage

// File: rtl/oag_short_imm.sv
// Expands a short immediate field into a full-width operand.
// The field value n stands for n+1. The negative form returns the two's complement of n+1.
// Assumes SIMM_W < DATA_W.
module oag_short_imm #(
    parameter int DATA_W = 16,
    parameter int SIMM_W = 4
) (
    input  logic [SIMM_W-1:0] simm,
    input  logic              neg,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] mag;

    // Forms the implied-plus-one magnitude and applies the sign.
    always_comb begin
        mag   = DATA_W'(simm) + DATA_W'(1);
        value = neg ? (~mag + DATA_W'(1)) : mag;
    end
endmodule

// File: rtl/oag_calc.sv
// Combinational value and address former for every addressing mode.
// Drives both register read numbers and assumes the register file answers in the same cycle.
// Flags the indirect mode so that the sequencer can run a memory read.
module oag_calc
    import oag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RAW    = 4,
    parameter int BRW    = 2,
    parameter int DISP_W = 8,
    parameter int SIMM_W = 4
) (
    input  logic [3:0]        mode,
    input  logic [RAW-1:0]    rb,
    input  logic [RAW-1:0]    rx,
    input  logic [BRW-1:0]    brp,
    input  logic [DISP_W-1:0] disp,
    input  logic [SIMM_W-1:0] simm,
    input  logic [DATA_W-1:0] aword,
    input  logic [DATA_W-1:0] ic,
    output logic [RAW-1:0]    rf_a_addr,
    input  logic [DATA_W-1:0] rf_a_data,
    output logic [RAW-1:0]    rf_b_addr,
    input  logic [DATA_W-1:0] rf_b_data,
    output logic [DATA_W-1:0] calc_val,
    output logic              calc_is_addr,
    output logic              calc_indirect
);
    // Base registers occupy the top 2^BRW entries of the register file.
    localparam int BASE_OFS = (1 << RAW) - (1 << BRW);

    logic              base_sel;
    logic [DATA_W-1:0] idx_term;
    logic [DATA_W-1:0] disp_sx;
    logic [DATA_W-1:0] disp_zx;
    logic [DATA_W-1:0] ic_cur;
    logic [DATA_W-1:0] simm_val;

    oag_short_imm #(.DATA_W(DATA_W), .SIMM_W(SIMM_W)) u_simm (
        .simm  (simm),
        .neg   (mode == M_ISN),
        .value (simm_val)
    );

    // Chooses the register numbers and prepares the addends.
    always_comb begin
        base_sel  = (mode == M_BASE) || (mode == M_BASEX);
        rf_a_addr = base_sel ? (RAW'(BASE_OFS) + RAW'(brp)) : rb;
        rf_b_addr = rx;
        idx_term  = (rx != '0) ? rf_b_data : '0;
        disp_sx   = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
        disp_zx   = DATA_W'(disp);
        ic_cur    = ic - DATA_W'(2);
    end

    // Selects the result for the decoded mode. All sums wrap.
    always_comb begin
        calc_val      = '0;
        calc_is_addr  = 1'b0;
        calc_indirect = 1'b0;
        case (mode)
            M_REG:   calc_val = rf_a_data;
            M_MDIR:  begin calc_val = aword + idx_term; calc_is_addr = 1'b1; end
            M_MIND:  begin calc_val = aword + idx_term; calc_is_addr = 1'b1; calc_indirect = 1'b1; end
            M_IMML:  calc_val = aword;
            M_IMMLX: calc_val = aword + idx_term;
            M_ISP:   calc_val = simm_val;
            M_ISN:   calc_val = simm_val;
            M_ICR:   begin calc_val = ic_cur + disp_sx; calc_is_addr = 1'b1; end
            M_BASE:  begin calc_val = rf_a_data + disp_zx; calc_is_addr = 1'b1; end
            M_BASEX: begin calc_val = rf_a_data + idx_term; calc_is_addr = 1'b1; end
            default: begin calc_val = '0; calc_is_addr = 1'b0; end
        endcase
    end

    // Checks the short immediate expander against the sign rules.
    always_comb begin
        if (mode == M_ISP) begin
            AST_SIMM_POS_NONZERO: assert (simm_val != '0 && !simm_val[DATA_W-1]); // R5
        end
        if (mode == M_ISN) begin
            AST_SIMM_NEG_SIGN: assert (simm_val[DATA_W-1]); // R5
        end
    end
endmodule

// File: rtl/oag_seq.sv
// Sequencer. It accepts a request, registers a single-cycle result, or runs the
// pointer read for the indirect mode (IDLE -> READ_PTR -> DONE).
// Assumes memory raises rvalid only while mem_req is high.
module oag_seq
    import oag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] calc_val,
    input  logic              calc_is_addr,
    input  logic              calc_indirect,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              is_addr
);
    oag_state_e state;
    logic       accept;

    // A request is taken in any state except while a pointer read is outstanding.
    always_comb accept = start && (state != S_READ_PTR);

    // Advances the state and captures the pointer or the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            mem_addr <= '0;
            result   <= '0;
            is_addr  <= 1'b0;
        end else begin
            case (state)
                S_READ_PTR: begin
                    if (mem_rvalid) begin
                        state   <= S_DONE;
                        result  <= mem_rdata;
                        is_addr <= 1'b1;
                    end
                end
                default: begin
                    if (accept && calc_indirect) begin
                        state    <= S_READ_PTR;
                        mem_addr <= calc_val;
                    end else if (accept) begin
                        state   <= S_DONE;
                        result  <= calc_val;
                        is_addr <= calc_is_addr;
                    end else begin
                        state <= S_IDLE;
                    end
                end
            endcase
        end
    end

    // Decodes the handshake outputs from the state.
    always_comb begin
        mem_req = (state == S_READ_PTR);
        done    = (state == S_DONE);
    end

    AST_SINGLE_CYCLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && !calc_indirect) |=> done); // R1
    AST_IND_REQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && calc_indirect) |=> mem_req); // R3
    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R3
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start) || $past(mem_rvalid))); // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && start) |=> !done); // R9
endmodule

// File: rtl/opnd_addr_gen.sv
// Top level of the operand address generator: the combinational former feeds the sequencer.
// Register reads are combinational through two ports. The memory read is request/valid.
module opnd_addr_gen
    import oag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RAW    = 4,
    parameter int BRW    = 2,
    parameter int DISP_W = 8,
    parameter int SIMM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [RAW-1:0]    rb,
    input  logic [RAW-1:0]    rx,
    input  logic [BRW-1:0]    brp,
    input  logic [DISP_W-1:0] disp,
    input  logic [SIMM_W-1:0] simm,
    input  logic [DATA_W-1:0] aword,
    input  logic [DATA_W-1:0] ic,
    output logic [RAW-1:0]    rf_a_addr,
    input  logic [DATA_W-1:0] rf_a_data,
    output logic [RAW-1:0]    rf_b_addr,
    input  logic [DATA_W-1:0] rf_b_data,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              is_addr
);
    logic [DATA_W-1:0] calc_val;
    logic              calc_is_addr;
    logic              calc_indirect;

    oag_calc #(
        .DATA_W(DATA_W), .RAW(RAW), .BRW(BRW), .DISP_W(DISP_W), .SIMM_W(SIMM_W)
    ) u_calc (
        .mode          (mode),
        .rb            (rb),
        .rx            (rx),
        .brp           (brp),
        .disp          (disp),
        .simm          (simm),
        .aword         (aword),
        .ic            (ic),
        .rf_a_addr     (rf_a_addr),
        .rf_a_data     (rf_a_data),
        .rf_b_addr     (rf_b_addr),
        .rf_b_data     (rf_b_data),
        .calc_val      (calc_val),
        .calc_is_addr  (calc_is_addr),
        .calc_indirect (calc_indirect)
    );

    oag_seq #(.DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .calc_val      (calc_val),
        .calc_is_addr  (calc_is_addr),
        .calc_indirect (calc_indirect),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .done          (done),
        .result        (result),
        .is_addr       (is_addr)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_req)); // R11
endmodule

// File: tb/opnd_addr_gen_tb_top.sv
// Self-checking bench with a behavioural register file, a memory with selectable latency
// and a reference model that predicts every output cycle by cycle.
module opnd_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [3:0]  rb = '0;
    logic [3:0]  rx = '0;
    logic [1:0]  brp = '0;
    logic [7:0]  disp = '0;
    logic [3:0]  simm = '0;
    logic [15:0] aword = '0;
    logic [15:0] ic = '0;
    logic [3:0]  rf_a_addr, rf_b_addr;
    logic [15:0] rf_a_data, rf_b_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid;
    logic [15:0] mem_rdata;
    logic        done;
    logic [15:0] result;
    logic        is_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int mem_lat = 1;
    int mem_cnt = 0;
    logic [15:0] regs [16];

    always #2 clk = ~clk;

    opnd_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rb(rb), .rx(rx),
        .brp(brp), .disp(disp), .simm(simm), .aword(aword), .ic(ic),
        .rf_a_addr(rf_a_addr), .rf_a_data(rf_a_data),
        .rf_b_addr(rf_b_addr), .rf_b_data(rf_b_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .result(result), .is_addr(is_addr)
    );

    assign rf_a_data = regs[rf_a_addr];
    assign rf_b_data = regs[rf_b_addr];

    function automatic logic [15:0] memw(input logic [15:0] a);
        return 16'((int'(a) * 7 + 16'h3C5A) & 16'hFFFF);
    endfunction

    // Memory model: answers a held request after mem_lat cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            mem_cnt    <= 0;
        end else if (mem_req && !mem_rvalid) begin
            if (mem_cnt == mem_lat - 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= memw(mem_addr);
                mem_cnt    <= 0;
            end else begin
                mem_cnt <= mem_cnt + 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
            mem_cnt    <= 0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Reference model: value, address flag and indirect flag from the requirements.
    function automatic void ref_model(input int m, input int rbv, input int rxv, input int brv,
                                      input int d, input int s, input int aw, input int icv,
                                      output int val, output bit isa, output bit ind);
        int idx = (rxv != 0) ? int'(regs[rxv]) : 0;
        int dsx = (d >= 128) ? d - 256 : d;
        ind = 0; isa = 0; val = 0;
        case (m)
            0: val = regs[rbv];
            1: begin val = aw + idx; isa = 1; end
            2: begin val = aw + idx; isa = 1; ind = 1; end
            3: val = aw;
            4: val = aw + idx;
            5: val = s + 1;
            6: val = -(s + 1);
            7: begin val = icv - 2 + dsx; isa = 1; end
            8: begin val = int'(regs[12 + brv]) + d; isa = 1; end
            9: begin val = int'(regs[12 + brv]) + idx; isa = 1; end
            default: begin val = 0; isa = 0; end
        endcase
        val = val & 16'hFFFF;
    endfunction

    // Runs one request from a falling edge and checks every cycle until done.
    task automatic do_op(input int m, input int rbv, input int rxv, input int brv,
                         input int d, input int s, input int aw, input int icv,
                         input int lat, input bit inject, input string req);
        int  ev;
        bit  isa, ind;
        ref_model(m, rbv, rxv, brv, d, s, aw, icv, ev, isa, ind);
        mode = 4'(m); rb = 4'(rbv); rx = 4'(rxv); brp = 2'(brv);
        disp = 8'(d); simm = 4'(s); aword = 16'(aw); ic = 16'(icv);
        mem_lat = lat;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ind) begin
            chk(mem_req === 1'b1, req, "mem_req", int'(mem_req), 1);
            chk(mem_addr === 16'(ev), req, "mem_addr", int'(mem_addr), ev);
            chk(done === 1'b0, req, "done early", int'(done), 0);
            if (inject) begin
                start = 1'b1; mode = 4'd0; rb = 4'd5;
            end
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                start = 1'b0;
                chk(done === 1'b0, inject ? "R9" : req, "done while reading", int'(done), 0);
                chk(mem_req === 1'b1, req, "mem_req held", int'(mem_req), 1);
                chk(mem_addr === 16'(ev), req, "mem_addr held", int'(mem_addr), ev);
            end
            @(negedge clk);
            chk(done === 1'b1, req, "done", int'(done), 1);
            chk(result === memw(16'(ev)), inject ? "R9" : req, "result",
                int'(result), int'(memw(16'(ev))));
            chk(is_addr === 1'b1, req, "is_addr", int'(is_addr), 1);
            chk(mem_req === 1'b0, req, "mem_req dropped", int'(mem_req), 0);
        end else begin
            chk(done === 1'b1, req, "done", int'(done), 1);
            chk(result === 16'(ev), req, "result", int'(result), ev);
            chk(is_addr === isa, req, "is_addr", int'(is_addr), int'(isa));
            chk(mem_req === 1'b0, req, "no mem_req", int'(mem_req), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 16'((i * 4919 + 514) & 16'hFFFF);
        regs[15] = 16'hFFF0;
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R11", "done in reset", int'(done), 0);
        chk(mem_req === 1'b0, "R11", "mem_req in reset", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R11", "done after reset", int'(done), 0);

        do_op(0, 5, 0, 0, 0, 0, 0, 0, 1, 0, "R1");
        do_op(0, 0, 9, 0, 0, 0, 0, 0, 1, 0, "R1");
        do_op(1, 0, 0, 0, 0, 0, 16'h1234, 0, 1, 0, "R2");
        do_op(1, 0, 3, 0, 0, 0, 16'h1234, 0, 1, 0, "R2");
        do_op(1, 0, 15, 0, 0, 0, 16'h0020, 0, 1, 0, "R8");
        do_op(2, 0, 0, 0, 0, 0, 16'h0400, 0, 1, 0, "R3");
        do_op(2, 0, 7, 0, 0, 0, 16'h0400, 0, 3, 0, "R3");
        do_op(2, 0, 2, 0, 0, 0, 16'h8000, 0, 3, 1, "R3");
        do_op(3, 0, 4, 0, 0, 0, 16'hBEEF, 0, 1, 0, "R4");
        do_op(4, 0, 4, 0, 0, 0, 16'hBEEF, 0, 1, 0, "R4");
        do_op(4, 0, 0, 0, 0, 0, 16'h00AA, 0, 1, 0, "R4");
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
        do_op(5, 0, 0, 0, 0, 15, 0, 0, 1, 0, "R5");
        do_op(6, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
        do_op(6, 0, 0, 0, 0, 15, 0, 0, 1, 0, "R5");
        do_op(7, 0, 0, 0, 16'h10, 0, 0, 16'h0100, 1, 0, "R6");
        do_op(7, 0, 0, 0, 16'h80, 0, 0, 16'h0100, 1, 0, "R6");
        do_op(7, 0, 0, 0, 16'hFF, 0, 0, 16'h0001, 1, 0, "R8");
        for (int b = 0; b < 4; b++) do_op(8, 0, 0, b, 16'hF0, 0, 0, 0, 1, 0, "R7");
        do_op(9, 0, 1, 2, 0, 0, 0, 0, 1, 0, "R7");
        do_op(9, 0, 0, 3, 0, 0, 0, 0, 1, 0, "R7");
        do_op(9, 0, 15, 3, 0, 0, 0, 0, 1, 0, "R8");
        do_op(12, 4, 4, 1, 16'h33, 3, 16'h5555, 16'h7777, 1, 0, "R10");
        do_op(15, 4, 4, 1, 16'h33, 3, 16'h5555, 16'h7777, 1, 0, "R10");
        @(negedge clk);
        chk(done === 1'b0, "R9", "done drops when idle", int'(done), 0);
        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule